// File: doc/BRIEF.md
# Vertical transfer pulse sequencer

This block produces one vertical transfer clock waveform for an image sensor timing generator. It runs on the pixel clock and is started by a horizontal line strobe. From the start it holds a programmed start level and inverts the output whenever the sequence position reaches one of up to three programmed toggle values. The position counter wraps after the programmed repeat value, and the waveform then begins again from the start level.

In normal mode the position is the pixel count since the last start, so toggles land on exact pixels. In scaled mode a prescaler divides the pixel clock by the length value and the toggle values count prescaler periods. Toggle value T then lands at pixel T times length. This gives coarser placement but allows pulses far longer than a line. With the sweep option set, line strobes after the first one are ignored so that a sequence can run across line boundaries. Without it, every line strobe restarts the sequence.

Top module: `vtp_seq`

## Requirements
- R1: After reset, vout is 0 and stays 0 until the first line strobe is sampled.
- R2: A restarting line strobe sampled on a clock edge sets vout to cfg_start_pol in the cycle that follows; that cycle is pixel offset 0.
- R3: In normal mode (cfg_mult_en=0), vout inverts in the cycle whose pixel offset equals an enabled toggle value T.
- R4: In scaled mode (cfg_mult_en=1), vout inverts at pixel offset T*cfg_len; with length 4 and toggle values 2 and 9, the edges fall at offsets 8 and 36.
- R5: In scaled mode, a cfg_len of 0 behaves as a length of 1.
- R6: The step count wraps after step cfg_rep has lasted one full prescaler period, so the period is (cfg_rep+1)*length pixels. At the wrap, vout returns to cfg_start_pol. A toggle value of 0, or a value above cfg_rep, never inverts the output.
- R7: Without sweep, a line strobe restarts the sequence in any cycle. If the strobe falls on the edge where a toggle would occur, the restart wins.
- R8: With sweep (cfg_sweep_en=1), line strobes after the first start are ignored and the sequence continues across lines.
- R9: Toggle slot i, which occupies bits [12*i+11:12*i] of cfg_tog_flat, is used only when i < cfg_tog_num.
- R10: Enabled slots holding equal values cause one inversion, not several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | Horizontal line start pulse |
| cfg_start_pol | input | 1 | Output level at sequence start |
| cfg_tog_flat | input | 36 | Three 12-bit toggle values, slot 0 in the low bits |
| cfg_tog_num | input | 2 | Number of toggle slots in use (0 to 3) |
| cfg_len | input | 10 | Prescaler length used in scaled mode |
| cfg_rep | input | 12 | Last step before the position counter wraps |
| cfg_mult_en | input | 1 | Scaled mode enable |
| cfg_sweep_en | input | 1 | Ignore line strobes once running |
| vout | output | 1 | Vertical transfer clock |

## Verification
Two pairs of events can land on the same edge. The first pair is a restarting line strobe and a toggle. The bench raises the strobe exactly on the edge where toggle value 5 would fire, and expects the start level rather than the inverted level. The second pair is the wrap and a toggle at the repeat value. Here the bench programs the highest toggle equal to cfg_rep and expects the edges at T*length, followed by a return to the start level at (cfg_rep+1)*length. A behavioural model in the bench judges every cycle of both cases alongside directed checks at fixed offsets.

// File: rtl/vtp_seq_pkg.sv
package vtp_seq_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD    = 2'd0,
      ACT_RESTART = 2'd1,
      ACT_ADVANCE = 2'd2
   } vtp_act_e;
endpackage

// File: rtl/vtp_prescale.sv
module vtp_prescale #(
   parameter int LEN_W    = 10,
   parameter bit HAS_MULT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv,
   input  logic             mult_en,
   input  logic [LEN_W-1:0] len,
   output logic [LEN_W-1:0] pre,
   output logic             last
);
   generate
      if (HAS_MULT) begin : g_scaled
         logic [LEN_W-1:0] pre_q;
         logic [LEN_W-1:0] eff_last;
         // a zero length divides by one, as does normal mode
         assign eff_last = (mult_en && (len != '0)) ? (len - 1'b1) : '0;
         assign last     = (pre_q == eff_last);
         assign pre      = pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (clear)  pre_q <= '0;
            else if (adv)    pre_q <= last ? '0 : pre_q + 1'b1;
         end
      end else begin : g_plain
         assign pre  = '0;
         assign last = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/vtp_stepper.sv
module vtp_stepper #(
   parameter int POS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv,
   input  logic [POS_W-1:0] rep,
   output logic [POS_W-1:0] step,
   output logic             at_rep
);
   logic [POS_W-1:0] step_q;
   assign step   = step_q;
   assign at_rep = (step_q == rep);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      step_q <= '0;
      else if (clear)  step_q <= '0;
      else if (adv)    step_q <= at_rep ? '0 : step_q + 1'b1;
   end
endmodule

// File: rtl/vtp_match.sv
module vtp_match #(
   parameter int POS_W = 12,
   parameter int NTOG  = 3,
   parameter int CNT_W = 2
) (
   input  logic [POS_W-1:0]      cand,
   input  logic [NTOG*POS_W-1:0] tog_flat,
   input  logic [CNT_W-1:0]      tog_num,
   output logic                  hit
);
   logic [NTOG-1:0] slot_hit;
   generate
      for (genvar i = 0; i < NTOG; i++) begin : g_slot
         assign slot_hit[i] = (i < int'(tog_num)) &&
                              (tog_flat[i*POS_W +: POS_W] == cand);
      end
   endgenerate
   // equal slots merge into a single inversion
   assign hit = |slot_hit;
endmodule

// File: rtl/vtp_seq.sv
module vtp_seq
   import vtp_seq_pkg::*;
#(
   parameter int POS_W    = 12,
   parameter int LEN_W    = 10,
   parameter int NTOG     = 3,
   parameter bit HAS_MULT = 1'b1,
   localparam int CNT_W   = $clog2(NTOG + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line_strobe,
   input  logic                  cfg_start_pol,
   input  logic [NTOG*POS_W-1:0] cfg_tog_flat,
   input  logic [CNT_W-1:0]      cfg_tog_num,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic [POS_W-1:0]      cfg_rep,
   input  logic                  cfg_mult_en,
   input  logic                  cfg_sweep_en,
   output logic                  vout
);
   generate
      if (POS_W < 2 || POS_W > 24) begin : g_bad_pos
         $error("vtp_seq: POS_W out of range");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("vtp_seq: LEN_W out of range");
      end
      if (NTOG < 1 || NTOG > 8) begin : g_bad_ntog
         $error("vtp_seq: NTOG out of range");
      end
   endgenerate

   vtp_act_e         act;
   logic             run_q, vout_q;
   logic             restart, adv;
   logic [LEN_W-1:0] pre;
   logic             pre_last;
   logic [POS_W-1:0] step, step_inc;
   logic             at_rep, hit, fire, wrap;

   always_comb begin
      if (line_strobe && (!run_q || !cfg_sweep_en)) act = ACT_RESTART;
      else if (run_q)                               act = ACT_ADVANCE;
      else                                          act = ACT_HOLD;
   end
   assign restart = (act == ACT_RESTART);
   assign adv     = (act == ACT_ADVANCE);

   vtp_prescale #(.LEN_W(LEN_W), .HAS_MULT(HAS_MULT)) u_pre (
      .clk(clk), .rst_n(rst_n), .clear(restart), .adv(adv),
      .mult_en(cfg_mult_en), .len(cfg_len), .pre(pre), .last(pre_last)
   );

   vtp_stepper #(.POS_W(POS_W)) u_step (
      .clk(clk), .rst_n(rst_n), .clear(restart), .adv(adv && pre_last),
      .rep(cfg_rep), .step(step), .at_rep(at_rep)
   );

   // compare against the step about to be entered so the edge is registered
   assign step_inc = step + 1'b1;

   vtp_match #(.POS_W(POS_W), .NTOG(NTOG), .CNT_W(CNT_W)) u_match (
      .cand(step_inc), .tog_flat(cfg_tog_flat), .tog_num(cfg_tog_num), .hit(hit)
   );

   assign wrap = adv && pre_last && at_rep;
   assign fire = adv && pre_last && !at_rep && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         vout_q <= 1'b0;
      end else begin
         case (act)
            ACT_RESTART: begin
               run_q  <= 1'b1;
               vout_q <= cfg_start_pol;
            end
            ACT_ADVANCE: begin
               if (wrap)      vout_q <= cfg_start_pol;
               else if (fire) vout_q <= ~vout_q;
            end
            default: ;
         endcase
      end
   end
   assign vout = vout_q;
endmodule

// File: rtl/vtp_seq_chk.sv
module vtp_seq_chk #(
   parameter int POS_W = 12,
   parameter int LEN_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_strobe,
   input logic             cfg_sweep_en,
   input logic             cfg_start_pol,
   input logic             vout,
   input logic             run_q,
   input logic             restart,
   input logic [LEN_W-1:0] pre,
   input logic             pre_last,
   input logic [POS_W-1:0] step,
   input logic             at_rep
);
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !vout);

   a_r2_start_level: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && !cfg_sweep_en) |=> (vout == $past(cfg_start_pol)));

   a_r4_edge_on_period: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && !$past(restart) && (vout != $past(vout)))
      |-> (pre == '0));

   a_r5_step_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !restart && !pre_last) |=> $stable(step));

   a_r6_wrap_level: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !restart && pre_last && at_rep)
      |=> (vout == $past(cfg_start_pol)) && (step == '0));
endmodule

bind vtp_seq vtp_seq_chk #(.POS_W(POS_W), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
   .cfg_sweep_en(cfg_sweep_en), .cfg_start_pol(cfg_start_pol), .vout(vout),
   .run_q(run_q), .restart(restart), .pre(pre), .pre_last(pre_last),
   .step(step), .at_rep(at_rep)
);

// File: tb/vtp_seq_test.sv
`timescale 1ns/1ps
module vtp_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_strobe = 1'b0;
   logic        cfg_start_pol = 1'b0;
   logic [35:0] cfg_tog_flat = '0;
   logic [1:0]  cfg_tog_num = '0;
   logic [9:0]  cfg_len = '0;
   logic [11:0] cfg_rep = '0;
   logic        cfg_mult_en = 1'b0;
   logic        cfg_sweep_en = 1'b0;
   logic        vout;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string tag = "R1";
   logic  smp [0:127];

   always #5 clk = ~clk;

   vtp_seq uut (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
      .cfg_start_pol(cfg_start_pol), .cfg_tog_flat(cfg_tog_flat),
      .cfg_tog_num(cfg_tog_num), .cfg_len(cfg_len), .cfg_rep(cfg_rep),
      .cfg_mult_en(cfg_mult_en), .cfg_sweep_en(cfg_sweep_en), .vout(vout)
   );

   // behavioural reference: pixel offset since start, folded by the period
   bit   m_run;
   int   m_off;
   logic exp_q;

   function automatic int eff_len();
      if (!cfg_mult_en) return 1;
      return (cfg_len == 0) ? 1 : int'(cfg_len);
   endfunction

   function automatic logic exp_at(int off);
      int cnt = 0;
      for (int i = 0; i < int'(cfg_tog_num); i++) begin
         int  t = int'(cfg_tog_flat[i*12 +: 12]);
         bit  dup = 1'b0;
         for (int j = 0; j < i; j++)
            if (int'(cfg_tog_flat[j*12 +: 12]) == t) dup = 1'b1;
         if (!dup && t >= 1 && t <= int'(cfg_rep) && t * eff_len() <= off) cnt++;
      end
      return cfg_start_pol ^ cnt[0];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 1'b0;
         m_off = 0;
         exp_q = 1'b0;
      end else begin
         if (line_strobe && (!m_run || !cfg_sweep_en)) begin
            m_run = 1'b1;
            m_off = 0;
         end else if (m_run) begin
            m_off = (m_off + 1) % ((int'(cfg_rep) + 1) * eff_len());
         end
         exp_q = m_run ? exp_at(m_off) : 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (vout !== exp_q) begin
            bad++;
            $display("FAIL %s model: vout=%0b expected=%0b", tag, vout, exp_q);
         end
      end
   end

   task automatic chk(string req, logic act, logic exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic do_reset(logic pol, int t0, int t1, int t2, int num,
                           int len, int rep, logic mult, logic sweep);
      @(negedge clk);
      rst_n = 1'b0;
      line_strobe = 1'b0;
      cfg_start_pol = pol;
      cfg_tog_flat = {12'(t2), 12'(t1), 12'(t0)};
      cfg_tog_num = 2'(num);
      cfg_len = 10'(len);
      cfg_rep = 12'(rep);
      cfg_mult_en = mult;
      cfg_sweep_en = sweep;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // leaves the bench at the negedge of pixel offset 0
   task automatic strobe();
      line_strobe = 1'b1;
      @(negedge clk);
      line_strobe = 1'b0;
   endtask

   task automatic run_samples(int n, int inj);
      for (int k = 0; k < n; k++) begin
         smp[k] = vout;
         if (k == inj) line_strobe = 1'b1;
         else if (k == inj + 1) line_strobe = 1'b0;
         @(negedge clk);
      end
      line_strobe = 1'b0;
   endtask

   initial begin
      // R1: idle after reset
      tag = "R1";
      do_reset(1'b1, 3, 0, 0, 1, 0, 10, 1'b0, 1'b0);
      chk("R1", vout, 1'b0, "reset level");
      repeat (6) @(negedge clk);
      chk("R1", vout, 1'b0, "idle without strobe");

      // R2 R3 R6: normal mode, three toggles, wrap after step 30
      tag = "R3";
      do_reset(1'b0, 5, 12, 20, 3, 0, 30, 1'b0, 1'b0);
      strobe();
      run_samples(40, -1);
      chk("R2", smp[0], 1'b0, "start level at offset 0");
      chk("R3", smp[4], 1'b0, "before toggle at 5");
      chk("R3", smp[5], 1'b1, "toggle at 5");
      chk("R3", smp[12], 1'b0, "toggle at 12");
      chk("R3", smp[20], 1'b1, "toggle at 20");
      chk("R6", smp[31], 1'b0, "wrap back to start level");
      chk("R6", smp[36], 1'b1, "toggle at 5 after wrap");

      // R9: only two slots enabled
      tag = "R9";
      do_reset(1'b0, 5, 12, 20, 2, 0, 30, 1'b0, 1'b0);
      strobe();
      run_samples(25, -1);
      chk("R9", smp[20], 1'b0, "disabled slot 2 ignored");

      // R4 R8: scaled mode, length 4, values 2 and 9, sweep with a stray strobe
      tag = "R4";
      do_reset(1'b0, 2, 9, 0, 2, 4, 9, 1'b1, 1'b1);
      strobe();
      run_samples(60, 20);
      chk("R4", smp[7], 1'b0, "before offset 8");
      chk("R4", smp[8], 1'b1, "edge at offset 8");
      chk("R8", smp[22], 1'b1, "strobe ignored under sweep");
      chk("R4", smp[35], 1'b1, "before offset 36");
      chk("R4", smp[36], 1'b0, "edge at offset 36");
      chk("R6", smp[48], 1'b1, "scaled repeat after 40 pixels");

      // R5: zero length acts as one
      tag = "R5";
      do_reset(1'b1, 3, 0, 0, 1, 0, 6, 1'b1, 1'b0);
      strobe();
      run_samples(12, -1);
      chk("R5", smp[2], 1'b1, "before offset 3");
      chk("R5", smp[3], 1'b0, "edge at offset 3");
      chk("R6", smp[7], 1'b1, "wrap after step 6");

      // R7: restart collides with the toggle at 5
      tag = "R7";
      do_reset(1'b0, 5, 30, 0, 2, 0, 50, 1'b0, 1'b0);
      strobe();
      run_samples(20, 4);
      chk("R7", smp[4], 1'b0, "level before collision");
      chk("R7", smp[5], 1'b0, "restart wins over toggle");
      chk("R7", smp[10], 1'b1, "toggle 5 pixels after restart");

      // R10: duplicate slot values
      tag = "R10";
      do_reset(1'b0, 6, 6, 10, 3, 0, 20, 1'b0, 1'b0);
      strobe();
      run_samples(12, -1);
      chk("R10", smp[6], 1'b1, "duplicate values invert once");
      chk("R10", smp[10], 1'b0, "next toggle");

      // R6: value 0 and value above repeat never fire
      tag = "R6";
      do_reset(1'b1, 0, 25, 0, 2, 0, 15, 1'b0, 1'b0);
      strobe();
      run_samples(40, -1);
      begin
         bit flat = 1'b1;
         for (int k = 0; k < 40; k++) if (smp[k] !== 1'b1) flat = 1'b0;
         chk("R6", flat, 1'b1, "no edge from value 0 or value above repeat");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule